// File: doc/BRIEF.md
# Single-Register I2C Write Master

This block is a bus master that issues one register write per request to a display controller on an I2C bus. A request carries a 7-bit target address, a control or register byte and one payload byte. The master frames them with a start condition, sends the three bytes most significant bit first, looks for the target's acknowledge after each byte, and closes with a stop condition. It has no read path, no repeated start, no multi-byte burst, no clock stretching and no arbitration.

SCL is a push-pull output because no other device drives it. SDA is open-drain: the block only asserts an output enable that pulls the line low, and an external pull-up supplies the high level, so the target can pull it low in the acknowledge slot. Bit timing comes from a divider. Each SCL period is four quarters, and each quarter lasts `div_sel + 1` clock cycles. With a 200 MHz clock, `div_sel = 55` gives an SCL rate of about 890 kHz.

Top module: `i2c_reg_writer`

## Requirements
- R1: After reset, `scl` is 1, `sda_oe` is 0, and `busy`, `done` and `ack_err` are 0.
- R2: A cycle with `req` high while `busy` is low starts a transaction, and `busy` is high from the next cycle. While `busy` is high, `req` and all request inputs are ignored.
- R3: Every quarter lasts `div_sel + 1` cycles. `div_sel` is captured when the request is accepted, and later changes to it do not alter the running transaction.
- R4: The start condition takes four quarters with `scl` high: `sda_oe` is 0 in the first two quarters and 1 in the last two.
- R5: Each bit takes four quarters. `scl` is 0 in quarters 0 and 1 and is 1 in quarters 2 and 3. `sda_oe` keeps its previous value in quarter 0 and takes the bit's value in quarters 1 to 3.
- R6: The bytes go out in this order: `{slave_addr, 1'b0}`, then `reg_byte`, then `data_byte`. Each byte is sent MSB first. A 0 bit is sent as `sda_oe = 1` and a 1 bit as `sda_oe = 0`.
- R7: In the ninth bit of each byte the master releases SDA (`sda_oe = 0` in quarters 1 to 3) and samples `sda_in` at the end of quarter 2. A high level sets `ack_err`. The transaction still sends all three bytes and the stop condition.
- R8: The stop condition takes six quarters. Quarter 0 has `scl` 0 with `sda_oe` held. Quarter 1 has `scl` 0 and `sda_oe` 1. Quarters 2 and 3 have `scl` 1 and `sda_oe` 1. Quarters 4 and 5 have `scl` 1 and `sda_oe` 0.
- R9: `done` is high for exactly one cycle, the first cycle after the last stop quarter, and `busy` is low in that cycle. A whole transaction occupies 118 quarters.
- R10: `ack_err` clears when a new request is accepted and holds its value until the next accepted request.
- R11: `scl` and `sda_oe` never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Request strobe, accepted only while idle |
| slave_addr | input | 7 | 7-bit target address |
| reg_byte | input | 8 | Register or control byte |
| data_byte | input | 8 | Payload byte |
| div_sel | input | DIV_W | Quarter-period length minus one, in clock cycles |
| sda_in | input | 1 | Sampled level of the SDA line |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse after the stop condition completes |
| ack_err | output | 1 | At least one byte of the last transaction was not acknowledged |
| scl | output | 1 | Bus clock, push-pull |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with the default `DIV_W = 8` and runs transactions with `div_sel` set to 0, 1, 3 and 55. The value 0 exercises the case where every cycle is a quarter boundary. The values 1 and 3 exercise multi-cycle quarters. The value 55 gives the 890 kHz bus rate at 200 MHz. A target model decodes the bytes from the bus and answers with configurable not-acknowledge patterns. The runs include a request held high during a transaction while the divider and address change, and a request accepted in the same cycle as `done`.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_BIT,
    PH_STOP
  } phase_e;

  localparam int NUM_BYTES      = 3;
  localparam int BITS_PER_SLOT  = 9;
  localparam int START_QTRS     = 4;
  localparam int BIT_QTRS       = 4;
  localparam int STOP_QTRS      = 6;
  localparam int ACK_BIT        = BITS_PER_SLOT - 1;
  localparam int ACK_SAMPLE_QTR = 2;
  localparam int SCL_HIGH_QTR   = 2;
  localparam int STOP_RELEASE   = 4;

endpackage

// File: rtl/i2cw_rst_sync.sv
module i2cw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_limit;

  assign at_limit = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && at_limit;

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

  assert_cnt_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/i2cw_bytesel.sv
module i2cw_bytesel
  import i2cw_pkg::*;
(
  input  logic [6:0] slave_addr,
  input  logic [7:0] reg_byte,
  input  logic [7:0] data_byte,
  input  logic [1:0] byte_idx,
  input  logic [3:0] bit_idx,
  output logic       bit_val,
  output logic       ack_slot
);

  localparam int SLOT_W = 8;

  logic [SLOT_W-1:0] slots [NUM_BYTES];
  logic [SLOT_W-1:0] cur_slot;
  logic [2:0]        msb_pos;

  assign slots[0] = {slave_addr, 1'b0};
  assign slots[1] = reg_byte;
  assign slots[2] = data_byte;

  always_comb begin
    cur_slot = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (byte_idx == 2'(i)) begin
        cur_slot = slots[i];
      end
    end
  end

  assign msb_pos  = 3'd7 - bit_idx[2:0];
  assign ack_slot = (bit_idx == 4'(ACK_BIT));
  assign bit_val  = ack_slot ? 1'b1 : cur_slot[msb_pos];

endmodule

// File: rtl/i2c_reg_writer.sv
module i2c_reg_writer
  import i2cw_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [6:0]       slave_addr,
  input  logic [7:0]       reg_byte,
  input  logic [7:0]       data_byte,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             sda_in,
  output logic             busy,
  output logic             done,
  output logic             ack_err,
  output logic             scl,
  output logic             sda_oe
);

  localparam logic [2:0] START_LAST = 3'(START_QTRS - 1);
  localparam logic [2:0] BIT_LAST   = 3'(BIT_QTRS - 1);
  localparam logic [2:0] STOP_LAST  = 3'(STOP_QTRS - 1);
  localparam logic [1:0] BYTE_LAST  = 2'(NUM_BYTES - 1);
  localparam logic [3:0] ACK_IDX    = 4'(ACK_BIT);

  logic rst_sync_n;

  phase_e           phase_q, phase_d;
  logic [2:0]       qtr_q, qtr_d;
  logic [3:0]       bit_q, bit_d;
  logic [1:0]       byte_q, byte_d;
  logic             scl_q, scl_d;
  logic             oe_q, oe_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [6:0]       addr_q;
  logic [7:0]       reg_q, data_q;
  logic [DIV_W-1:0] div_q;

  logic accept;
  logic tick;
  logic run;
  logic nxt_bit_val;
  logic nxt_ack_slot;
  logic ack_sample;

  i2cw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign run    = (phase_q != PH_IDLE);
  assign accept = (phase_q == PH_IDLE) && req;

  i2cw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .limit (div_q),
    .tick  (tick)
  );

  i2cw_bytesel u_sel (
    .slave_addr (addr_q),
    .reg_byte   (reg_q),
    .data_byte  (data_q),
    .byte_idx   (byte_d),
    .bit_idx    (bit_d),
    .bit_val    (nxt_bit_val),
    .ack_slot   (nxt_ack_slot)
  );

  // Sequencer: position within the transaction, advanced once per quarter.
  always_comb begin
    phase_d = phase_q;
    qtr_d   = qtr_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          phase_d = PH_START;
          qtr_d   = '0;
          bit_d   = '0;
          byte_d  = '0;
        end
      end
      PH_START: begin
        if (tick) begin
          if (qtr_q == START_LAST) begin
            phase_d = PH_BIT;
            qtr_d   = '0;
          end else begin
            qtr_d = qtr_q + 3'd1;
          end
        end
      end
      PH_BIT: begin
        if (tick) begin
          if (qtr_q == BIT_LAST) begin
            qtr_d = '0;
            if (bit_q == ACK_IDX) begin
              bit_d = '0;
              if (byte_q == BYTE_LAST) begin
                phase_d = PH_STOP;
              end else begin
                byte_d = byte_q + 2'd1;
              end
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end else begin
            qtr_d = qtr_q + 3'd1;
          end
        end
      end
      PH_STOP: begin
        if (tick) begin
          if (qtr_q == STOP_LAST) begin
            phase_d = PH_IDLE;
            qtr_d   = '0;
            done_d  = 1'b1;
          end else begin
            qtr_d = qtr_q + 3'd1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Line levels for the quarter being entered; quarter 0 of a low phase holds SDA.
  always_comb begin
    scl_d = scl_q;
    oe_d  = oe_q;
    if (tick) begin
      unique case (phase_d)
        PH_START: begin
          scl_d = 1'b1;
          oe_d  = (qtr_d >= 3'(SCL_HIGH_QTR));
        end
        PH_BIT: begin
          scl_d = (qtr_d >= 3'(SCL_HIGH_QTR));
          if (qtr_d != 3'd0) begin
            oe_d = nxt_ack_slot ? 1'b0 : !nxt_bit_val;
          end
        end
        PH_STOP: begin
          scl_d = (qtr_d >= 3'(SCL_HIGH_QTR));
          if (qtr_d != 3'd0) begin
            oe_d = (qtr_d < 3'(STOP_RELEASE));
          end
        end
        default: begin
          scl_d = 1'b1;
          oe_d  = 1'b0;
        end
      endcase
    end
  end

  assign ack_sample = tick && (phase_q == PH_BIT) && (bit_q == ACK_IDX) &&
                      (qtr_q == 3'(ACK_SAMPLE_QTR));

  always_comb begin
    err_d = err_q;
    if (accept) begin
      err_d = 1'b0;
    end else if (ack_sample && sda_in) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      qtr_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      scl_q   <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      qtr_q   <= qtr_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      scl_q   <= scl_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      reg_q  <= '0;
      data_q <= '0;
      div_q  <= '0;
    end else if (accept) begin
      addr_q <= slave_addr;
      reg_q  <= reg_byte;
      data_q <= data_byte;
      div_q  <= div_sel;
    end
  end

  assign busy    = run;
  assign done    = done_q;
  assign ack_err = err_q;
  assign scl     = scl_q;
  assign sda_oe  = oe_q;

  assert_scl_sda_apart_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(scl_q) |-> $stable(oe_q));

  assert_bit_sda_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_BIT && $past(phase_q) == PH_BIT && scl_q && $past(scl_q)) |-> $stable(oe_q));

  assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(oe_q) && phase_q == PH_START) |-> scl_q);

  assert_stop_edge_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(oe_q) && phase_q == PH_STOP) |-> (scl_q && $past(scl_q)));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_IDLE && req) |=> (phase_q == PH_START));

  assert_div_frozen_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(div_q));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);

  assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> (phase_q != PH_STOP && $past(phase_q) == PH_STOP));

  assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(err_q) |-> ($past(phase_q) == PH_BIT && $past(bit_q) == ACK_IDX));

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_IDLE && !req) |=> $stable(err_q));

endmodule

// File: tb/sim_i2c_reg_writer.sv
`timescale 1ns/1ps
module sim_i2c_reg_writer;

  localparam int DIV_W = 8;
  localparam logic [3:0] IDLE_V = 4'b0010;

  logic             clk;
  logic             rst_n;
  logic             req;
  logic [6:0]       slave_addr;
  logic [7:0]       reg_byte;
  logic [7:0]       data_byte;
  logic [DIV_W-1:0] div_sel;
  logic             sda_in;
  logic             busy, done, ack_err, scl, sda_oe;

  int tests;
  int fails;
  int cyc;
  logic settle;

  logic [3:0] exp_q[$];
  logic [3:0] cur;
  logic [2:0] nack_req;
  logic [2:0] nack_l;
  logic [7:0] expb [3];
  logic [7:0] got [3];
  logic       acc_flag;

  logic pull;
  logic prev_scl, prev_oe;
  int   falls;

  i2c_reg_writer #(.DIV_W(DIV_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .slave_addr (slave_addr),
    .reg_byte   (reg_byte),
    .data_byte  (data_byte),
    .div_sel    (div_sel),
    .sda_in     (sda_in),
    .busy       (busy),
    .done       (done),
    .ack_err    (ack_err),
    .scl        (scl),
    .sda_oe     (sda_oe)
  );

  assign sda_in = !(sda_oe || pull);

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push_qtr(input bit s, input bit o, input int d);
    for (int i = 0; i <= d; i++) exp_q.push_back({1'b1, 1'b0, s, o});
  endtask

  // Behavioural waveform builder: one entry per clock after acceptance.
  task automatic build(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int d);
    logic [7:0] bytes [3];
    bit prev;
    bit o;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    exp_q.delete();
    push_qtr(1, 0, d); push_qtr(1, 0, d); push_qtr(1, 1, d); push_qtr(1, 1, d);
    prev = 1'b1;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 9; b++) begin
        o = (b < 8) ? !bytes[k][7-b] : 1'b0;
        push_qtr(0, prev, d); push_qtr(0, o, d); push_qtr(1, o, d); push_qtr(1, o, d);
        prev = o;
      end
    end
    push_qtr(0, prev, d); push_qtr(0, 1, d); push_qtr(1, 1, d);
    push_qtr(1, 1, d); push_qtr(1, 0, d); push_qtr(1, 0, d);
    exp_q.push_back(4'b0110);
  endtask

  // Reference model, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      cur = IDLE_V;
      acc_flag = 1'b0;
      nack_l = '0;
    end else if (!cur[3] && req) begin
      expb[0] = {slave_addr, 1'b0};
      expb[1] = reg_byte;
      expb[2] = data_byte;
      nack_l  = nack_req;
      build(expb[0], expb[1], expb[2], int'(div_sel));
      cur = exp_q.pop_front();
      acc_flag = 1'b1;
    end else begin
      acc_flag = 1'b0;
      if (exp_q.size() > 0) cur = exp_q.pop_front();
      else cur = IDLE_V;
    end
  end

  // Comparison and target model, on every falling edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (!rst_n) begin
      pull = 1'b0; falls = 0; prev_scl = 1'b1; prev_oe = 1'b0;
    end else if (settle) begin
      if (scl !== cur[1] || sda_oe !== cur[0])
        check(0, "R3/R4/R5/R7/R8 bus waveform", {scl, sda_oe}, cur[1:0]);
      else tests++;
      check(busy === cur[3], "R2 busy", busy, cur[3]);
      check(done === cur[2], "R9 done", done, cur[2]);
      check(!((scl !== prev_scl) && (sda_oe !== prev_oe)), "R11 scl/sda same-cycle change",
            {scl, sda_oe}, {prev_scl, prev_oe});
      if (acc_flag) check(ack_err === 1'b0, "R10 ack_err cleared on accept", ack_err, 0);
      if (cur[2]) begin
        for (int k = 0; k < 3; k++)
          check(got[k] === expb[k], "R6 decoded byte", got[k], expb[k]);
        check(ack_err === (nack_l != 3'b000), "R7 ack_err after nack pattern",
              ack_err, (nack_l != 3'b000));
      end
      // Target: detect start, count SCL falls, pull the acknowledge slot, decode bytes.
      if (scl && prev_scl && sda_oe && !prev_oe) begin
        falls = 0; pull = 1'b0;
      end else if (!scl && prev_scl) begin
        falls++;
        if (falls % 9 == 0 && falls <= 27) pull = !nack_l[falls/9 - 1];
        else if (falls % 9 == 1) pull = 1'b0;
      end else if (scl && !prev_scl && falls >= 1 && falls <= 27 && ((falls - 1) % 9) < 8) begin
        got[(falls-1)/9] = {got[(falls-1)/9][6:0], sda_in};
      end
      prev_scl = scl;
      prev_oe  = sda_oe;
    end
  end

  task automatic launch(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                        input logic [DIV_W-1:0] dv, input logic [2:0] nk);
    @(negedge clk);
    slave_addr = a; reg_byte = r; data_byte = d; div_sel = dv; nack_req = nk;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; settle = 1'b0;
    req = 1'b0; slave_addr = '0; reg_byte = '0; data_byte = '0; div_sel = '0;
    nack_req = '0; pull = 1'b0;
    got[0] = '0; got[1] = '0; got[2] = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    settle = 1'b1;
    // R1: reset state
    check({scl, sda_oe, busy, done, ack_err} === 5'b10000, "R1 reset outputs",
          {scl, sda_oe, busy, done, ack_err}, 5'b10000);

    // Fastest divider, all bytes acknowledged.
    launch(7'h3C, 8'h00, 8'hA5, 8'd0, 3'b000);
    wait_done();

    // R10: ack_err holds while idle.
    repeat (10) @(negedge clk);
    check(ack_err === 1'b0, "R10 ack_err idle hold", ack_err, 0);

    // Nack on register byte.
    launch(7'h7F, 8'h40, 8'h00, 8'd3, 3'b010);
    wait_done();
    repeat (7) @(negedge clk);
    check(ack_err === 1'b1, "R10 ack_err sticky", ack_err, 1);

    // R2/R3: request and inputs change while busy; must be ignored.
    launch(7'h01, 8'hFF, 8'h80, 8'd3, 3'b001);
    repeat (20) @(negedge clk);
    req = 1'b1; div_sel = 8'd0; slave_addr = 7'h55; reg_byte = 8'h12; nack_req = 3'b111;
    repeat (60) @(negedge clk);
    req = 1'b0;
    wait_done();

    // Back-to-back: request held into the done cycle.
    launch(7'h2A, 8'hC3, 8'h3C, 8'd1, 3'b100);
    while (!done) @(negedge clk);
    slave_addr = 7'h15; reg_byte = 8'h5A; data_byte = 8'h96; div_sel = 8'd1; nack_req = 3'b000;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(busy === 1'b1, "R2 accept in done cycle", busy, 1);
    wait_done();

    // Bus rate near 890 kHz at 200 MHz; nack on data byte.
    launch(7'h3F, 8'h81, 8'h7E, 8'd55, 3'b100);
    wait_done();
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule